// File: doc/BRIEF.md
# Outbound PCI Address Translator

This block maps a 36-bit internal bus address onto a 64-bit PCI bus address for requests that leave the chip. It handles two kinds of request: memory and I/O. Each request carries its address, a type bit and a 2-bit memory window index.

For a memory request, the low 32 bits of the internal address are kept. The upper half of the result comes from a per-window 32-bit value register. The block also raises a dual-address-cycle flag whenever that upper half is non-zero. For an I/O request, only the low 16 bits of the address are kept, and they are merged with a single I/O window value register. The result is a plain 32-bit address.

Software or a configuration agent loads the five value registers through a small write port. A 3-bit select on that port names the target register. The translated result appears one clock after the request. The request's type and window index travel along with the result.

Top module: `pci_out_xlat`

## Requirements
- R1: After reset, all four memory window values and the I/O window value are zero, and `out_valid` and `out_addr` are zero.
- R2: For a memory request, `out_addr[31:0]` equals `req_addr[31:0]`, and `req_addr[35:32]` has no effect on the result.
- R3: For a memory request, `out_addr[63:32]` equals the value register of the window selected by `req_win`. Index values 0 to 3 pick windows 0 to 3.
- R4: For a memory request, `out_dac` is 1 exactly when `out_addr[63:32]` is non-zero. A window whose value is zero therefore always gives `out_dac` = 0, which is a single address cycle.
- R5: For an I/O request (`req_is_io` = 1), `out_addr` equals the zero-extended value of (I/O window value OR `req_addr[15:0]`). Its bits 63:32 are zero and `out_dac` is 0.
- R6: A write to the I/O window value stores `wr_data[31:16]` with bits 15:0 forced to zero. Because of this, the low 16 bits of an I/O result always equal `req_addr[15:0]`.
- R7: When `wr_en` = 1, `wr_sel` codes 0 to 3 load memory window 0 to 3 and code 4 loads the I/O window. Codes 5 to 7 change no register.
- R8: The result has one cycle of latency. `out_valid` equals the previous cycle's `req_valid`. When it is 1, `out_is_io` and `out_win` equal the previous cycle's `req_is_io` and `req_win`.
- R9: A write accepted in the same cycle as a request does not affect that request. It affects only requests in later cycles.
- R10: In a cycle where `out_valid` is 0, `out_addr`, `out_dac`, `out_is_io` and `out_win` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Value register write strobe |
| wr_sel | input | 3 | Write target: 0-3 memory window, 4 I/O window, 5-7 none |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_win | input | 2 | Memory window index |
| req_addr | input | 36 | Internal bus address |
| out_valid | output | 1 | Translated result valid |
| out_is_io | output | 1 | Type of the translated request |
| out_win | output | 2 | Window index of the translated request |
| out_addr | output | 64 | Translated PCI address |
| out_dac | output | 1 | 1 = dual address cycle needed |

## Verification
The bench builds the block with its default widths: a 36-bit internal address, four windows, a 32-bit upper value and a 16-bit I/O field. With four windows, every value of the 2-bit index selects a real window. With a 3-bit select, the three unused codes 5 to 7 can be driven and shown to be ignored.

A bench parameter picks the window multiplexer variant, so either the indexed form or the AND-OR form can be checked with the same stimulus. Random write data is biased toward zero, so both the single- and the dual-address-cycle outcomes occur on every window.

// File: rtl/pci_out_xlat_pkg.sv
`timescale 1ns/1ps
package pci_out_xlat_pkg;

   // Decoded target of a value register write
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_MEM  = 2'd1,
      TGT_IO   = 2'd2
   } wr_tgt_e;

   // Multiplexer variants for picking the window value
   localparam int MUX_INDEXED = 0;
   localparam int MUX_ANDOR   = 1;

endpackage

// File: rtl/pci_out_xlat_regs.sv
`timescale 1ns/1ps
module pci_out_xlat_regs
   import pci_out_xlat_pkg::*;
#(
   parameter int NUM_MWIN = 4,
   parameter int UPPER_W  = 32,
   parameter int LOW_W    = 32,
   parameter int IO_W     = 16,
   parameter int SEL_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [UPPER_W-1:0] wr_data,
   output logic [UPPER_W-1:0] mwin_val [NUM_MWIN],
   output logic [LOW_W-1:0]   io_val
);

   localparam logic [SEL_W-1:0] IO_SEL = SEL_W'(NUM_MWIN);

   wr_tgt_e tgt;

   always_comb begin
      if (!wr_en)
         tgt = TGT_NONE;
      else if (wr_sel < IO_SEL)
         tgt = TGT_MEM;
      else if (wr_sel == IO_SEL)
         tgt = TGT_IO;
      else
         tgt = TGT_NONE;
   end

   for (genvar w = 0; w < NUM_MWIN; w++) begin : g_win
      logic [UPPER_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (tgt == TGT_MEM && wr_sel == SEL_W'(w))
            val_q <= wr_data;
      end
      assign mwin_val[w] = val_q;
   end

   logic [LOW_W-IO_W-1:0] io_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         io_hi_q <= '0;
      else if (tgt == TGT_IO)
         io_hi_q <= wr_data[LOW_W-1:IO_W];
   end

   assign io_val = {io_hi_q, IO_W'(0)};

endmodule

// File: rtl/pci_out_xlat_mem.sv
`timescale 1ns/1ps
module pci_out_xlat_mem
   import pci_out_xlat_pkg::*;
#(
   parameter int NUM_MWIN  = 4,
   parameter int UPPER_W   = 32,
   parameter int LOW_W     = 32,
   parameter int WIN_W     = 2,
   parameter int MUX_STYLE = MUX_INDEXED,
   localparam int PADDR_W  = UPPER_W + LOW_W
) (
   input  logic [UPPER_W-1:0] mwin_val [NUM_MWIN],
   input  logic [WIN_W-1:0]   win,
   input  logic [LOW_W-1:0]   addr_lo,
   output logic [PADDR_W-1:0] pci_addr,
   output logic               dac
);

   logic [UPPER_W-1:0] upper;

   if (MUX_STYLE == MUX_INDEXED) begin : g_idx
      assign upper = mwin_val[win];
   end else begin : g_andor
      always_comb begin
         upper = '0;
         for (int i = 0; i < NUM_MWIN; i++) begin
            if (win == WIN_W'(i))
               upper = upper | mwin_val[i];
         end
      end
   end

   assign pci_addr = {upper, LOW_W'(0)} | PADDR_W'(addr_lo);
   assign dac      = |pci_addr[PADDR_W-1:LOW_W];

endmodule

// File: rtl/pci_out_xlat_io.sv
`timescale 1ns/1ps
module pci_out_xlat_io #(
   parameter int UPPER_W  = 32,
   parameter int LOW_W    = 32,
   parameter int IO_W     = 16,
   localparam int PADDR_W = UPPER_W + LOW_W
) (
   input  logic [LOW_W-1:0]   io_val,
   input  logic [IO_W-1:0]    addr_lo,
   output logic [PADDR_W-1:0] pci_addr
);

   assign pci_addr = PADDR_W'(io_val | LOW_W'(addr_lo));

endmodule

// File: rtl/pci_out_xlat.sv
`timescale 1ns/1ps
module pci_out_xlat
   import pci_out_xlat_pkg::*;
#(
   parameter int IADDR_W   = 36,
   parameter int UPPER_W   = 32,
   parameter int LOW_W     = 32,
   parameter int IO_W      = 16,
   parameter int NUM_MWIN  = 4,
   parameter int MUX_STYLE = MUX_INDEXED,
   localparam int WIN_W    = $clog2(NUM_MWIN),
   localparam int SEL_W    = $clog2(NUM_MWIN + 1),
   localparam int PADDR_W  = UPPER_W + LOW_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [UPPER_W-1:0] wr_data,
   input  logic               req_valid,
   input  logic               req_is_io,
   input  logic [WIN_W-1:0]   req_win,
   input  logic [IADDR_W-1:0] req_addr,
   output logic               out_valid,
   output logic               out_is_io,
   output logic [WIN_W-1:0]   out_win,
   output logic [PADDR_W-1:0] out_addr,
   output logic               out_dac
);

   // Elaboration-time parameter checks
   if (IADDR_W <= LOW_W)
      $error("pci_out_xlat: IADDR_W must exceed LOW_W");
   if (IO_W >= LOW_W)
      $error("pci_out_xlat: IO_W must be below LOW_W");
   if (UPPER_W != LOW_W)
      $error("pci_out_xlat: UPPER_W must equal LOW_W");
   if (NUM_MWIN < 2 || (1 << WIN_W) != NUM_MWIN)
      $error("pci_out_xlat: NUM_MWIN must be a power of two, at least 2");
   if (MUX_STYLE != MUX_INDEXED && MUX_STYLE != MUX_ANDOR)
      $error("pci_out_xlat: unknown MUX_STYLE");

   logic [UPPER_W-1:0] mwin_val [NUM_MWIN];
   logic [LOW_W-1:0]   io_val;
   logic [PADDR_W-1:0] mem_addr;
   logic               mem_dac;
   logic [PADDR_W-1:0] io_addr;
   logic               unused_hi;

   // Internal address bits above the 4 GB boundary are discarded
   assign unused_hi = ^req_addr[IADDR_W-1:LOW_W];

   pci_out_xlat_regs #(
      .NUM_MWIN (NUM_MWIN),
      .UPPER_W  (UPPER_W),
      .LOW_W    (LOW_W),
      .IO_W     (IO_W),
      .SEL_W    (SEL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .mwin_val (mwin_val),
      .io_val   (io_val)
   );

   pci_out_xlat_mem #(
      .NUM_MWIN  (NUM_MWIN),
      .UPPER_W   (UPPER_W),
      .LOW_W     (LOW_W),
      .WIN_W     (WIN_W),
      .MUX_STYLE (MUX_STYLE)
   ) u_mem (
      .mwin_val (mwin_val),
      .win      (req_win),
      .addr_lo  (req_addr[LOW_W-1:0]),
      .pci_addr (mem_addr),
      .dac      (mem_dac)
   );

   pci_out_xlat_io #(
      .UPPER_W (UPPER_W),
      .LOW_W   (LOW_W),
      .IO_W    (IO_W)
   ) u_io (
      .io_val   (io_val),
      .addr_lo  (req_addr[IO_W-1:0]),
      .pci_addr (io_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_is_io <= 1'b0;
         out_win   <= '0;
         out_addr  <= '0;
         out_dac   <= 1'b0;
      end else if (req_valid) begin
         out_valid <= 1'b1;
         out_is_io <= req_is_io;
         out_win   <= req_win;
         out_addr  <= req_is_io ? io_addr : mem_addr;
         out_dac   <= req_is_io ? 1'b0 : mem_dac;
      end else begin
         out_valid <= 1'b0;
         out_is_io <= 1'b0;
         out_win   <= '0;
         out_addr  <= '0;
         out_dac   <= 1'b0;
      end
   end

endmodule

// File: rtl/pci_out_xlat_chk.sv
`timescale 1ns/1ps
module pci_out_xlat_chk #(
   parameter int IADDR_W = 36,
   parameter int LOW_W   = 32,
   parameter int IO_W    = 16,
   parameter int WIN_W   = 2,
   parameter int PADDR_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_is_io,
   input logic [WIN_W-1:0]   req_win,
   input logic [IADDR_W-1:0] req_addr,
   input logic               out_valid,
   input logic               out_is_io,
   input logic [WIN_W-1:0]   out_win,
   input logic [PADDR_W-1:0] out_addr,
   input logic               out_dac
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && req_valid |=> out_valid && out_is_io == $past(req_is_io) && out_win == $past(req_win));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !req_valid |=> !out_valid && out_addr == '0 && !out_dac && !out_is_io && out_win == '0);

   // R2
   mem_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && req_valid && !req_is_io |=> out_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]));

   // R4
   dac_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_is_io |-> out_dac == (out_addr[PADDR_W-1:LOW_W] != '0));

   // R5
   io_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_is_io |-> !out_dac && out_addr[PADDR_W-1:LOW_W] == '0);

   // R6
   io_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && req_valid && req_is_io |=> out_addr[IO_W-1:0] == $past(req_addr[IO_W-1:0]));

endmodule

bind pci_out_xlat pci_out_xlat_chk #(
   .IADDR_W (IADDR_W),
   .LOW_W   (LOW_W),
   .IO_W    (IO_W),
   .WIN_W   (WIN_W),
   .PADDR_W (PADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_is_io (req_is_io),
   .req_win   (req_win),
   .req_addr  (req_addr),
   .out_valid (out_valid),
   .out_is_io (out_is_io),
   .out_win   (out_win),
   .out_addr  (out_addr),
   .out_dac   (out_dac)
);

// File: tb/tb_pci_out_xlat.sv
`timescale 1ns/1ps
module tb_pci_out_xlat;

   localparam int TB_MUX_STYLE = 0;
   localparam int MAX_CYC      = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic        req_is_io = 1'b0;
   logic [1:0]  req_win = '0;
   logic [35:0] req_addr = '0;
   logic        out_valid;
   logic        out_is_io;
   logic [1:0]  out_win;
   logic [63:0] out_addr;
   logic        out_dac;

   pci_out_xlat #(.MUX_STYLE(TB_MUX_STYLE)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .req_valid (req_valid),
      .req_is_io (req_is_io),
      .req_win   (req_win),
      .req_addr  (req_addr),
      .out_valid (out_valid),
      .out_is_io (out_is_io),
      .out_win   (out_win),
      .out_addr  (out_addr),
      .out_dac   (out_dac)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench model of the value registers
   logic [31:0] m_win [4];
   logic [31:0] m_io;

   // Expected result of the request driven in the previous cycle
   bit          have_exp = 1'b0;
   logic        e_valid, e_io, e_dac;
   logic [1:0]  e_win;
   logic [63:0] e_addr;
   string       e_ctx;

   task automatic check(input string ctx, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
      end
   endtask

   function automatic logic [63:0] model_addr(input logic io, input logic [1:0] w, input logic [35:0] a);
      if (io) return {32'h0, m_io | {16'h0, a[15:0]}};
      return {m_win[w], a[31:0]};
   endfunction

   task automatic model_write(input logic [2:0] sel, input logic [31:0] d);
      if (sel < 3'd4)       m_win[sel[1:0]] = d;
      else if (sel == 3'd4) m_io = {d[31:16], 16'h0};
   endtask

   task automatic compare_prev();
      if (!have_exp) return;
      check(e_ctx, "R8 valid", 64'(out_valid), 64'(e_valid));
      if (e_valid) begin
         check(e_ctx, "R8 type", 64'(out_is_io), 64'(e_io));
         check(e_ctx, "R8 window", 64'(out_win), 64'(e_win));
         if (e_io) begin
            check(e_ctx, "R5 io address", out_addr, e_addr);
            check(e_ctx, "R5 io dac", 64'(out_dac), 64'(0));
         end else begin
            check(e_ctx, "R2 low half", 64'(out_addr[31:0]), 64'(e_addr[31:0]));
            check(e_ctx, "R3 high half", 64'(out_addr[63:32]), 64'(e_addr[63:32]));
            check(e_ctx, "R4 dac", 64'(out_dac), 64'(e_dac));
         end
      end else begin
         check(e_ctx, "R10 idle address", out_addr, 64'h0);
         check(e_ctx, "R10 idle dac", 64'(out_dac), 64'h0);
      end
   endtask

   task automatic step(input logic v, input logic io, input logic [1:0] w, input logic [35:0] a,
                       input logic we, input logic [2:0] ws, input logic [31:0] wd, input string ctx);
      @(negedge clk);
      compare_prev();
      req_valid = v;
      req_is_io = io;
      req_win   = w;
      req_addr  = a;
      wr_en     = we;
      wr_sel    = ws;
      wr_data   = wd;
      e_valid   = v;
      e_io      = v ? io : 1'b0;
      e_win     = v ? w : 2'b0;
      e_addr    = v ? model_addr(io, w, a) : 64'h0;
      e_dac     = v && !io && (e_addr[63:32] != 32'h0);
      e_ctx     = ctx;
      have_exp  = 1'b1;
      if (we) model_write(ws, wd);
   endtask

   initial begin
      void'($urandom(32'd20071));
      for (int i = 0; i < 4; i++) m_win[i] = '0;
      m_io = '0;
      repeat (3) @(negedge clk);
      // R1: outputs cleared during reset
      check("reset", "R1 valid", 64'(out_valid), 64'h0);
      check("reset", "R1 address", out_addr, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every value register starts at zero
      for (int w = 0; w < 4; w++)
         step(1'b1, 1'b0, 2'(w), 36'hF_8765_4321, 1'b0, 3'd0, 32'h0, "R1 reset window");
      step(1'b1, 1'b1, 2'd0, 36'hA_BCDE_F012, 1'b0, 3'd0, 32'h0, "R1 reset io");

      // R3 / R4: all-ones window, upper nibble of the address dropped (R2)
      step(1'b0, 1'b0, 2'd0, 36'h0, 1'b1, 3'd3, 32'hFFFF_FFFF, "R7 load window 3");
      step(1'b1, 1'b0, 2'd3, 36'hF_1234_5678, 1'b0, 3'd0, 32'h0, "R3 window 3 dac");
      step(1'b1, 1'b0, 2'd2, 36'hF_1234_5678, 1'b0, 3'd0, 32'h0, "R2 top nibble dropped");

      // R6: I/O value low half forced to zero
      step(1'b0, 1'b0, 2'd0, 36'h0, 1'b1, 3'd4, 32'hABCD_FFFF, "R6 load io");
      step(1'b1, 1'b1, 2'd1, 36'hF_FFFF_1234, 1'b0, 3'd0, 32'h0, "R6 io merge");

      // R7: unused select codes change nothing
      for (int s = 5; s < 8; s++)
         step(1'b0, 1'b0, 2'd0, 36'h0, 1'b1, 3'(s), 32'h5555_5555, "R7 unused code");
      for (int w = 0; w < 4; w++)
         step(1'b1, 1'b0, 2'(w), 36'h0_0000_0010, 1'b0, 3'd0, 32'h0, "R7 windows unchanged");
      step(1'b1, 1'b1, 2'd0, 36'h0_0000_0020, 1'b0, 3'd0, 32'h0, "R7 io unchanged");

      // R9: write and request in the same cycle
      step(1'b1, 1'b0, 2'd1, 36'h0_0000_0100, 1'b1, 3'd1, 32'h0000_0001, "R9 same cycle old value");
      step(1'b1, 1'b0, 2'd1, 36'h0_0000_0100, 1'b0, 3'd0, 32'h0, "R9 next cycle new value");

      // R4: clearing a window returns it to single address cycles
      step(1'b0, 1'b0, 2'd0, 36'h0, 1'b1, 3'd3, 32'h0, "R4 clear window 3");
      step(1'b1, 1'b0, 2'd3, 36'hF_FFFF_FFFF, 1'b0, 3'd0, 32'h0, "R4 zero window sac");

      // R10: idle cycle
      step(1'b0, 1'b1, 2'd3, 36'hF_FFFF_FFFF, 1'b0, 3'd0, 32'h0, "R10 idle");

      // Constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] r;
         logic [31:0] d;
         r = {$urandom(), $urandom()};
         d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom();
         step($urandom_range(0, 3) != 0, $urandom_range(0, 9) < 3, 2'($urandom_range(0, 3)), r[35:0],
              $urandom_range(0, 9) < 3, 3'($urandom_range(0, 7)), d, "random");
      end
      step(1'b0, 1'b0, 2'd0, 36'h0, 1'b0, 3'd0, 32'h0, "flush");
      @(negedge clk);
      compare_prev();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog: actual hung expected finish within %0d cycles", MAX_CYC);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule